// File: doc/BRIEF.md
# Banked Interrupt Status Controller

This block collects interrupt requests from several identical banks of 32 source lines each. Every bank holds three stored registers: a sticky pending status, an enable vector and a capture-mask vector. From these it derives a gated status, one request line towards the processor and an encoded vector. A source that is high at a clock edge sets its pending bit, unless its mask bit blocks it. The bit then stays set until software clears it by writing a one to it.

Software reaches the registers through a single synchronous port with byte addresses. The banks are laid out at a fixed stride, and each register sits at a fixed 8-byte offset within its bank. Each bank also presents the index of the highest enabled pending source. Software takes that index as the source to service, because lower-order bits are not trusted to be meaningful.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, every status, enable and mask bit is 0, every bit of `cpu_req_o` and `irq_vec_o` is 0, and `reg_rdata_o` is 0.
- R2: Bank n starts at byte address n*0x28. Within a bank, pending status is at +0x00, enable at +0x08, gated status at +0x10, raw source level at +0x18 and capture mask at +0x20. A read strobe returns the addressed register on `reg_rdata_o` after the next clock edge. Any other address reads as 0.
- R3: A source that is high at a clock edge sets its pending bit, provided its mask bit is 0. The bit stays set after the source goes low.
- R4: Writing to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears every pending bit of that bank.
- R5: If a capture and a clearing write hit the same bit at the same edge, the bit stays pending.
- R6: The enable register reads back what was last written to it. The gated status at +0x10 reads as pending AND enable.
- R7: `cpu_req_o[n]` is 1 exactly when bank n's gated status is nonzero. A pending source whose enable bit is 0 does not raise the request.
- R8: `irq_vec_o[n*5 +: 5]` gives the bit position of the most significant set bit of bank n's gated status. It is 0 when that status is zero.
- R9: A mask bit of 1 stops its source from setting the pending bit. Bits that are already pending are not affected by the mask.
- R10: A read at +0x18 returns the levels of the bank's 32 source lines at the read edge.
- R11: Writes to the gated-status offset, to the raw-level offset and to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | 160 | Source levels; bank n occupies bits n*32 +: 32 |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| cpu_req_o | output | 5 | Per-bank request to the processor |
| irq_vec_o | output | 25 | Per-bank 5-bit index of highest gated pending source |

## Verification
A source capture and a write-one-to-clear of the same status bit can land on the same edge. The bench first makes a bit pending. At one edge it then holds that source high while it writes a one to the same status bit. After that edge it reads the status back, and expects the bit still set and the request and vector still pointing at it. A second clearing write, with the source low, must then empty the bit. This shows that the clear works and that only the simultaneous capture kept the bit alive.

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
  parameter int NUM_BANKS   = 5,
  parameter int LINES       = 32,
  parameter int ADDR_W      = 8,
  parameter int BANK_STRIDE = 40
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_BANKS*LINES-1:0]   irq_src_i,
  input  logic                         reg_we_i,
  input  logic                         reg_re_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [LINES-1:0]             reg_wdata_i,
  output logic [LINES-1:0]             reg_rdata_o,
  output logic [NUM_BANKS-1:0]         cpu_req_o,
  output logic [NUM_BANKS*$clog2(LINES)-1:0] irq_vec_o
);
  localparam int VEC_W   = $clog2(LINES);
  localparam int OFS_PND = 0;
  localparam int OFS_EN  = 8;
  localparam int OFS_OUT = 16;
  localparam int OFS_RAW = 24;
  localparam int OFS_MSK = 32;

  logic [LINES-1:0] pnd_q [NUM_BANKS];
  logic [LINES-1:0] en_q  [NUM_BANKS];
  logic [LINES-1:0] msk_q [NUM_BANKS];
  logic [LINES-1:0] src_w [NUM_BANKS];
  logic [LINES-1:0] cap_w [NUM_BANKS];
  logic [LINES-1:0] clr_w [NUM_BANKS];
  logic [LINES-1:0] out_w [NUM_BANKS];
  logic [LINES-1:0] rd_mux;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE = b * BANK_STRIDE;
    logic hit_pnd, hit_en, hit_msk;
    logic [VEC_W-1:0] vec;

    assign hit_pnd  = reg_we_i && (reg_addr_i == ADDR_W'(BASE + OFS_PND));
    assign hit_en   = reg_we_i && (reg_addr_i == ADDR_W'(BASE + OFS_EN));
    assign hit_msk  = reg_we_i && (reg_addr_i == ADDR_W'(BASE + OFS_MSK));
    assign src_w[b] = irq_src_i[b*LINES +: LINES];
    assign cap_w[b] = src_w[b] & ~msk_q[b];
    assign clr_w[b] = hit_pnd ? reg_wdata_i : '0;
    assign out_w[b] = pnd_q[b] & en_q[b];
    assign cpu_req_o[b] = |out_w[b];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pnd_q[b] <= '0;
        en_q[b]  <= '0;
        msk_q[b] <= '0;
      end else begin
        pnd_q[b] <= (pnd_q[b] & ~clr_w[b]) | cap_w[b];
        if (hit_en)  en_q[b]  <= reg_wdata_i;
        if (hit_msk) msk_q[b] <= reg_wdata_i;
      end
    end

    always_comb begin
      vec = '0;
      for (int i = 0; i < LINES; i++)
        if (out_w[b][i]) vec = VEC_W'(i);
    end
    assign irq_vec_o[b*VEC_W +: VEC_W] = vec;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (en_q[b] == '0 && msk_q[b] == '0));
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pnd_q[b]) & ~$past(clr_w[b])) & ~pnd_q[b]) == '0);
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cap_w[b]) & ~pnd_q[b]) == '0);
    assert_req_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req_o[b] |-> (en_q[b] != '0));
    assert_vec_is_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req_o[b] |-> ((out_w[b] >> vec) == LINES'(1)));
    assert_vec_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req_o[b] |-> (vec == '0));
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr_i == ADDR_W'(b*BANK_STRIDE + OFS_PND)) rd_mux = pnd_q[b];
      if (reg_addr_i == ADDR_W'(b*BANK_STRIDE + OFS_EN))  rd_mux = en_q[b];
      if (reg_addr_i == ADDR_W'(b*BANK_STRIDE + OFS_OUT)) rd_mux = out_w[b];
      if (reg_addr_i == ADDR_W'(b*BANK_STRIDE + OFS_RAW)) rd_mux = src_w[b];
      if (reg_addr_i == ADDR_W'(b*BANK_STRIDE + OFS_MSK)) rd_mux = msk_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        reg_rdata_o <= '0;
    else if (reg_re_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: tb/irq_bank_ctrl_tb_top.sv
module irq_bank_ctrl_tb_top;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [159:0] irq_src_i = '0;
  logic         reg_we_i = 0, reg_re_i = 0;
  logic [7:0]   reg_addr_i = '0;
  logic [31:0]  reg_wdata_i = '0;
  logic [31:0]  reg_rdata_o;
  logic [4:0]   cpu_req_o;
  logic [24:0]  irq_vec_o;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_bank_ctrl dut_i (.clk, .rst_n, .irq_src_i, .reg_we_i, .reg_re_i,
    .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .cpu_req_o, .irq_vec_o);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk); reg_we_i = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_re_i = 1; reg_addr_i = a;
    @(negedge clk); reg_re_i = 0; d = reg_rdata_o;
  endtask

  task automatic pulse(int bank, logic [31:0] bits);
    @(negedge clk); irq_src_i[bank*32 +: 32] = bits;
    @(negedge clk); irq_src_i[bank*32 +: 32] = '0;
  endtask

  function automatic logic [31:0] vec(int bank);
    return {27'd0, irq_vec_o[bank*5 +: 5]};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    check("R1 rdata", reg_rdata_o, 0);
    check("R1 cpu_req", {27'd0, cpu_req_o}, 0);
    check("R1 vec", {7'd0, irq_vec_o}, 0);
    for (int b = 0; b < 5; b++) begin
      rd(8'(b*40 + 8), d);  check("R1 enable", d, 0);
      rd(8'(b*40), d);      check("R1 status", d, 0);
      rd(8'(b*40 + 32), d); check("R1 mask", d, 0);
    end
  endtask

  task automatic t_latch;
    logic [31:0] d;
    pulse(1, 32'h80);
    rd(8'h28, d); check("R3 sticky status", d, 32'h80);
    check("R7 no req while disabled", {27'd0, cpu_req_o}, 0);
    rd(8'h38, d); check("R6 gated zero", d, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(8'h30, 32'hFFFF_0080);
    rd(8'h30, d); check("R6 enable readback", d, 32'hFFFF_0080);
    rd(8'h38, d); check("R6 gated status", d, 32'h80);
    check("R7 req bank1", {27'd0, cpu_req_o}, 32'h2);
    check("R8 vec bank1", vec(1), 7);
  endtask

  task automatic t_msb;
    logic [31:0] d;
    pulse(1, 32'h0010_0008);
    rd(8'h38, d); check("R6 gated two bits", d, 32'h0010_0080);
    check("R8 msb vector", vec(1), 20);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(8'h28, 32'h0010_0000);
    rd(8'h28, d); check("R4 partial clear", d, 32'h88);
    check("R8 vec after clear", vec(1), 7);
    wr(8'h28, 32'h0);
    rd(8'h28, d); check("R4 zero write keeps", d, 32'h88);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, d); check("R4 all-ones clear", d, 0);
    check("R7 req dropped", {27'd0, cpu_req_o}, 0);
    check("R8 vec idle", vec(1), 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr(8'h58, 32'h8000_0000);
    pulse(2, 32'h8000_0000);
    @(negedge clk);
    irq_src_i[64 +: 32] = 32'h8000_0000;
    reg_we_i = 1; reg_addr_i = 8'h50; reg_wdata_i = 32'h8000_0000;
    @(negedge clk);
    irq_src_i[64 +: 32] = '0; reg_we_i = 0;
    rd(8'h50, d); check("R5 set wins over clear", d, 32'h8000_0000);
    check("R5 req kept", {27'd0, cpu_req_o}, 32'h4);
    check("R8 vec top bit", vec(2), 31);
    wr(8'h50, 32'h8000_0000);
    rd(8'h50, d); check("R4 clear after collision", d, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(8'h98, 32'h1);
    rd(8'h98, d); check("R9 mask readback", d, 32'h1);
    pulse(3, 32'h3);
    rd(8'h78, d); check("R9 masked source not captured", d, 32'h2);
    wr(8'h98, 32'h2);
    rd(8'h78, d); check("R9 pending kept under mask", d, 32'h2);
  endtask

  task automatic t_raw;
    logic [31:0] d;
    @(negedge clk); irq_src_i[128 +: 32] = 32'hA5A5_0000;
    rd(8'hB8, d); check("R10 raw level", d, 32'hA5A5_0000);
    irq_src_i[128 +: 32] = 32'h0000_0F0F;
    rd(8'hB8, d); check("R10 raw follows", d, 32'h0000_0F0F);
    irq_src_i[128 +: 32] = '0;
  endtask

  task automatic t_map;
    logic [31:0] d;
    pulse(0, 32'h20);
    wr(8'hA8, 32'h1234_5678);
    rd(8'hA8, d); check("R2 bank4 enable", d, 32'h1234_5678);
    rd(8'h80, d); check("R2 bank3 enable untouched", d, 0);
    rd(8'h04, d); check("R2 unmapped read", d, 0);
    rd(8'hC8, d); check("R2 beyond last bank", d, 0);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'hC8, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R11 status untouched", d, 32'h20);
    rd(8'h08, d); check("R11 enable untouched", d, 0);
    rd(8'h20, d); check("R11 mask untouched", d, 0);
    rd(8'hC0, d); check("R11 bank4 mask untouched", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre: begin end
    check("R1 rdata in reset", reg_rdata_o, 0);
    rst_n = 1;
    t_reset;
    t_latch;
    t_enable;
    t_msb;
    t_w1c;
    t_collide;
    t_mask;
    t_raw;
    t_map;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule